// File: doc/BRIEF.md
# Buffered Configuration Port Transfer Engine

This peripheral sits on a simple memory-mapped bus and moves blocks of 32-bit words between an on-chip word buffer and a configuration data port. The host first fills the buffer through the lower part of the bus window. It then programs a byte length and a starting word index in two registers. A write to the direction register launches the transfer. A configure transfer streams buffer words out to the port. A readback transfer pulls port words into the buffer.

The host learns that a transfer has finished by polling a status word. That word carries a done flag, four bits that are always one, and four flags that come straight from the configuration port. A bus write to the status address stops the engine at once. The port side is a plain handshake: a write strobe with its data, a read strobe with data returned in the same cycle, and a busy input that stalls the engine.

Top module: `cfg_xfer_engine`

## Requirements
- R1: A bus write to byte address 4*i, with i below BUF_WORDS, stores the data in buffer word i. A bus read returns the stored word on bus_rdata one cycle after bus_rd is sampled.
- R2: Registers sit at byte address 4*BUF_WORDS: length at +0, start index at +4, direction at +8, status at +12. Length and start index reset to 0 and read back the last value written. The direction address reads as 0.
- R3: Writing bit 0 = 0 to the direction address starts a configure transfer of length>>2 words. Each word is driven on port_wdata with port_wr high, in order from buffer word start, start+1, and so on. port_wr and port_rd are never high together.
- R4: Writing bit 0 = 1 to the direction address starts a readback of length>>2 words. In every cycle where port_rd is high, port_rdata is stored into the current buffer word, beginning at start and moving up by one each time.
- R5: While port_busy is high, neither strobe is asserted and the transfer does not advance. While port_busy is low, one word moves per cycle.
- R6: Status bit 0 reads 0 from the cycle after a launch until the last word has moved. It reads 1 from the cycle after the last word and after reset.
- R7: Status bits 4..1 always read 1. Bits 8, 7, 6 and 5 reflect port_cfgerr, port_dalign, port_rip and port_abort_n. Bits 31..9 read 0.
- R8: A launch with length>>2 equal to 0 asserts no strobe, and status bit 0 stays 1.
- R9: The buffer word index wraps modulo BUF_WORDS during a transfer.
- R10: A direction write while a transfer is running is ignored. The running transfer keeps its direction and word count.
- R11: Any bus write to the status address stops a running transfer. No further strobe is asserted and status bit 0 returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Bus write enable |
| bus_rd | input | 1 | Bus read enable |
| bus_addr | input | ADDR_W | Bus byte address |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Registered bus read data |
| port_wr | output | 1 | Port write strobe (configure) |
| port_wdata | output | 32 | Port write data |
| port_rd | output | 1 | Port read strobe (readback) |
| port_rdata | input | 32 | Port read data, valid with port_rd |
| port_busy | input | 1 | Port stall request |
| port_cfgerr | input | 1 | Port configuration error flag |
| port_dalign | input | 1 | Port data-aligned flag |
| port_rip | input | 1 | Port readback-in-progress flag |
| port_abort_n | input | 1 | Port abort flag, active low |

## Verification
The bench builds the engine with BUF_WORDS = 16, which places the registers at 0x40 and makes ADDR_W equal to 7. With so small a buffer, a four-word transfer that starts at index 14 crosses the wrap point. The whole buffer can also be loaded and checked in a few dozen cycles. A port model inserts stalls in a fixed pattern or holds busy high throughout. This brings the stall, abort and ignored-relaunch cases within reach in short runs.

// File: rtl/cfg_xfer_engine.sv
module cfg_xfer_engine #(
  parameter int BUF_WORDS = 512
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                bus_wr,
  input  logic                                bus_rd,
  input  logic [$clog2(BUF_WORDS)+2:0]        bus_addr,
  input  logic [31:0]                         bus_wdata,
  output logic [31:0]                         bus_rdata,
  output logic                                port_wr,
  output logic [31:0]                         port_wdata,
  output logic                                port_rd,
  input  logic [31:0]                         port_rdata,
  input  logic                                port_busy,
  input  logic                                port_cfgerr,
  input  logic                                port_dalign,
  input  logic                                port_rip,
  input  logic                                port_abort_n
);
  localparam int IDX_W  = $clog2(BUF_WORDS);
  localparam int ADDR_W = IDX_W + 3;

  logic [31:0]      mem [BUF_WORDS];
  logic [31:0]      len_q, start_q;
  logic             running, dir_q;
  logic [IDX_W-1:0] idx_q;
  logic [29:0]      left_q;

  wire              reg_sel  = bus_addr[ADDR_W-1];
  wire [1:0]        rsel     = bus_addr[3:2];
  wire [IDX_W-1:0]  bidx     = bus_addr[IDX_W+1:2];
  wire              wr_len   = bus_wr && reg_sel && rsel == 2'd0;
  wire              wr_start = bus_wr && reg_sel && rsel == 2'd1;
  wire              wr_dir   = bus_wr && reg_sel && rsel == 2'd2;
  wire              wr_stat  = bus_wr && reg_sel && rsel == 2'd3;
  wire [29:0]       nwords   = len_q[31:2];
  wire              step     = running && !port_busy;
  wire              unused_addr = &{1'b0, bus_addr[1:0]};

  wire [31:0] status = {23'd0, port_cfgerr, port_dalign, port_rip, port_abort_n,
                        4'hF, ~running};

  assign port_wr    = step && !dir_q;
  assign port_rd    = step && dir_q;
  assign port_wdata = mem[idx_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q   <= '0;
      start_q <= '0;
      running <= 1'b0;
      dir_q   <= 1'b0;
      idx_q   <= '0;
      left_q  <= '0;
    end else begin
      if (wr_len)   len_q   <= bus_wdata;
      if (wr_start) start_q <= bus_wdata;
      if (wr_stat) begin
        running <= 1'b0;
      end else if (wr_dir && !running) begin
        if (nwords != '0) begin
          running <= 1'b1;
          dir_q   <= bus_wdata[0];
          idx_q   <= start_q[IDX_W-1:0];
          left_q  <= nwords;
        end
      end else if (step) begin
        idx_q  <= idx_q + 1'b1;
        left_q <= left_q - 1'b1;
        if (left_q == 30'd1) running <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (port_rd)
      mem[idx_q] <= port_rdata;
    else if (bus_wr && !reg_sel)
      mem[bidx] <= bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (!reg_sel)
        bus_rdata <= mem[bidx];
      else
        case (rsel)
          2'd0:    bus_rdata <= len_q;
          2'd1:    bus_rdata <= start_q;
          2'd2:    bus_rdata <= '0;
          default: bus_rdata <= status;
        endcase
    end
  end
endmodule

module cfg_xfer_engine_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              port_wr,
  input logic              port_rd,
  input logic              port_busy,
  input logic              running
);
  wire stat_hit = bus_addr[ADDR_W-1] && bus_addr[3:2] == 2'd3;

  // R5
  busy_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_busy |-> (!port_wr && !port_rd));

  // R3
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(port_wr && port_rd));

  // R11
  abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && stat_hit) |=> (!running && !port_wr && !port_rd));

  // R7
  fixed_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && stat_hit) |=> (bus_rdata[4:1] == 4'hF && bus_rdata[31:9] == '0));

  // R6
  done_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && stat_hit) |=> (bus_rdata[0] == !$past(running)));

  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (!port_wr && !port_rd));
endmodule

bind cfg_xfer_engine cfg_xfer_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .port_wr(port_wr),
  .port_rd(port_rd), .port_busy(port_busy), .running(running)
);

// File: tb/tb_cfg_xfer_engine.sv
module tb_cfg_xfer_engine;
  localparam int W  = 16;
  localparam int AW = $clog2(W) + 3;
  localparam logic [AW-1:0] A_LEN   = AW'(W*4);
  localparam logic [AW-1:0] A_START = AW'(W*4 + 4);
  localparam logic [AW-1:0] A_DIR   = AW'(W*4 + 8);
  localparam logic [AW-1:0] A_STAT  = AW'(W*4 + 12);
  localparam logic [31:0]   RB_BASE = 32'hA5000000;

  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic port_wr, port_rd;
  logic [31:0] port_wdata, port_rdata = '0;
  logic port_busy = 0;
  logic port_cfgerr = 0, port_dalign = 1, port_rip = 0, port_abort_n = 1;

  int total = 0, bad = 0;
  int stall_mode = 0, cyc = 0, rb_cnt = 0, cap_n = 0, viol = 0;
  logic [31:0] cap [64];
  logic [31:0] exp_buf [W];

  always #4 clk = ~clk;

  cfg_xfer_engine #(.BUF_WORDS(W)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .port_wr(port_wr), .port_wdata(port_wdata), .port_rd(port_rd),
    .port_rdata(port_rdata), .port_busy(port_busy), .port_cfgerr(port_cfgerr),
    .port_dalign(port_dalign), .port_rip(port_rip), .port_abort_n(port_abort_n)
  );

  // port model: drive at negedge+1, observe at negedge+2
  always begin
    @(negedge clk);
    #1;
    cyc++;
    port_rdata = RB_BASE + 32'(rb_cnt);
    port_busy  = (stall_mode == 1) ? (cyc % 3 != 0) : (stall_mode == 2);
    #1;
    if (port_busy && (port_wr || port_rd)) viol++;
    if (port_wr && cap_n < 64) begin cap[cap_n] = port_wdata; cap_n++; end
    if (port_rd) rb_cnt++;
  end

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic bwr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic brd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic wait_done();
    logic [31:0] s;
    for (int i = 0; i < 500; i++) begin
      brd(A_STAT, s);
      if (s[0]) return;
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    brd(A_LEN, d);   chk("R2 len reset", d, 0);
    brd(A_START, d); chk("R2 start reset", d, 0);
    brd(A_STAT, d);  chk("R6 R7 status reset", d, 32'h0BF);
  endtask

  task automatic t_buffer();
    logic [31:0] d;
    for (int i = 0; i < W; i++) begin
      exp_buf[i] = 32'hC0DE0000 + 32'(i * 32'h111);
      bwr(AW'(i*4), exp_buf[i]);
    end
    for (int i = 0; i < W; i += 5) begin
      brd(AW'(i*4), d); chk("R1 buffer readback", d, exp_buf[i]);
    end
  endtask

  task automatic t_regs();
    logic [31:0] d;
    bwr(A_LEN, 32'h12345678); brd(A_LEN, d); chk("R2 len rw", d, 32'h12345678);
    bwr(A_START, 32'h9);      brd(A_START, d); chk("R2 start rw", d, 32'h9);
    brd(A_DIR, d); chk("R2 dir reads zero", d, 0);
  endtask

  task automatic t_configure();
    logic [31:0] d;
    stall_mode = 1; cap_n = 0;
    bwr(A_START, 2); bwr(A_LEN, 24); bwr(A_DIR, 0);
    brd(A_STAT, d); chk("R6 busy after launch", {31'd0, d[0]}, 0);
    wait_done();
    chk("R3 configure count", 32'(cap_n), 6);
    for (int k = 0; k < 6; k++) chk("R3 configure word", cap[k], exp_buf[2+k]);
    chk("R5 no strobe while busy", 32'(viol), 0);
    stall_mode = 0;
  endtask

  task automatic t_wrap();
    cap_n = 0;
    bwr(A_START, W-2); bwr(A_LEN, 16); bwr(A_DIR, 0);
    wait_done();
    chk("R9 wrap count", 32'(cap_n), 4);
    chk("R9 wrap word0", cap[0], exp_buf[W-2]);
    chk("R9 wrap word1", cap[1], exp_buf[W-1]);
    chk("R9 wrap word2", cap[2], exp_buf[0]);
    chk("R9 wrap word3", cap[3], exp_buf[1]);
  endtask

  task automatic t_readback();
    logic [31:0] d;
    int base;
    stall_mode = 1; cap_n = 0; base = rb_cnt;
    bwr(A_START, 5); bwr(A_LEN, 12); bwr(A_DIR, 1);
    wait_done();
    chk("R4 readback count", 32'(rb_cnt - base), 3);
    chk("R4 no port writes", 32'(cap_n), 0);
    for (int k = 0; k < 3; k++) begin
      brd(AW'((5+k)*4), d); chk("R4 readback word", d, RB_BASE + 32'(base + k));
      exp_buf[5+k] = RB_BASE + 32'(base + k);
    end
    brd(AW'(8*4), d); chk("R4 neighbour untouched", d, exp_buf[8]);
    stall_mode = 0;
  endtask

  task automatic t_zero();
    logic [31:0] d;
    int base;
    cap_n = 0; base = rb_cnt;
    bwr(A_LEN, 3); bwr(A_DIR, 0);
    brd(A_STAT, d); chk("R8 zero length done", {31'd0, d[0]}, 1);
    bwr(A_DIR, 1);
    repeat (4) @(negedge clk);
    chk("R8 zero length no strobe", 32'(cap_n + rb_cnt - base), 0);
  endtask

  task automatic t_ignore();
    int base;
    stall_mode = 1; cap_n = 0; base = rb_cnt;
    bwr(A_START, 0); bwr(A_LEN, 32); bwr(A_DIR, 0);
    bwr(A_LEN, 4); bwr(A_DIR, 1);
    wait_done();
    chk("R10 relaunch ignored count", 32'(cap_n), 8);
    chk("R10 no readback", 32'(rb_cnt - base), 0);
    chk("R10 last word", cap[7], exp_buf[7]);
    stall_mode = 0;
  endtask

  task automatic t_abort();
    logic [31:0] d;
    stall_mode = 2; cap_n = 0;
    bwr(A_START, 0); bwr(A_LEN, 40); bwr(A_DIR, 0);
    brd(A_STAT, d); chk("R6 running while stalled", {31'd0, d[0]}, 0);
    bwr(A_STAT, 32'hFEFE);
    brd(A_STAT, d); chk("R11 abort done", {31'd0, d[0]}, 1);
    stall_mode = 0;
    repeat (20) @(negedge clk);
    chk("R11 no strobe after abort", 32'(cap_n), 0);
  endtask

  task automatic t_flags();
    logic [31:0] d;
    @(negedge clk);
    port_cfgerr = 1; port_dalign = 0; port_rip = 1; port_abort_n = 0;
    brd(A_STAT, d); chk("R7 port flags", d, 32'h15F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_buffer();
    t_regs();
    t_configure();
    t_wrap();
    t_readback();
    t_zero();
    t_ignore();
    t_abort();
    t_flags();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule